// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits next to a direct-mapped data cache. It catches the lines that the cache throws out, so a later conflict miss can often be served locally instead of travelling to the next memory level. Each slot keeps a valid bit, a whole line of data, and the complete line address as its tag. The buffer has no index, so the tag must identify the line on its own.

The cache controller uses three groups of signals. It presents a line address on the lookup port only after its own array has missed, so the cache's single-cycle hit path is not slowed. The buffer compares that address against every slot at once and answers in the same cycle with a hit flag, the line data, and a forward flag that tells the controller to go to the next level. When the cache evicts a line, the controller offers it on the insert port. On a buffer hit the controller can request a swap: the hit line moves into the cache, and the line it displaces takes over the freed slot in the same clock edge.

A new insert goes to a rotating allocation pointer, so when every slot is full the line that has been in the buffer longest is the one replaced.

Top module: `victim_buffer`

## Requirements
- R1: After reset every slot is invalid, and a lookup of any address returns `lk_hit`=0.
- R2: When `lk_valid`=1 and a valid slot holds a tag equal to `lk_addr`, `lk_hit`=1 and `lk_data` equals that slot's line in the same cycle. No two valid slots ever hold the same tag.
- R3: `lk_fwd` is 1 exactly when `lk_valid`=1 and `lk_hit`=0. When `lk_valid`=0, both `lk_hit` and `lk_fwd` are 0.
- R4: An insert (`ins_valid`=1) of an address no valid slot holds writes the slot at the allocation pointer. The pointer starts at slot 0 after reset and advances by one, wrapping at `N_ENTRIES`. With all slots full, the earliest-inserted line is the one lost.
- R5: An insert of an address that a valid slot already holds overwrites that slot's data and leaves the allocation pointer where it was.
- R6: When an insert and a lookup name the same address in one cycle, the insert takes priority: `lk_hit`=1 and `lk_data` equals `ins_data` in that cycle.
- R7: A swap (`sw_req`=1 with a lookup hit and no insert in that cycle) replaces the hit slot with `sw_addr`/`sw_data` at the next edge if `sw_vic_valid`=1. If `sw_vic_valid`=0, the slot is invalidated instead. The allocation pointer does not move.
- R8: `sw_req` has no effect on any slot when the lookup misses, when `lk_valid`=0, or when `ins_valid`=1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request, raised after a cache miss |
| lk_addr | input | ADDR_W | Line address to look up |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_data | output | LINE_W | Line data on hit, zero otherwise |
| lk_fwd | output | 1 | Lookup missed; go to next level |
| ins_valid | input | 1 | Evicted line offered for insertion |
| ins_addr | input | ADDR_W | Line address of evicted line |
| ins_data | input | LINE_W | Data of evicted line |
| sw_req | input | 1 | Swap the hit slot with the displaced cache line |
| sw_vic_valid | input | 1 | Displaced cache line is valid |
| sw_addr | input | ADDR_W | Line address of displaced cache line |
| sw_data | input | LINE_W | Data of displaced cache line |

## Verification
The bench first fills past capacity to confirm that the earliest-inserted slot is the one lost. A design using a wrong pointer, or one that fills holes first, would return a hit for a line that should be gone. It re-inserts a resident address; a design that allocates a second slot would lose an unrelated line too early and could answer a lookup from a stale copy. It also issues an insert and a lookup of the same address together, which a design without the bypass would report as a forwarded miss. Finally, it swaps with an invalid displaced line, and requests a swap alongside an insert or a missing lookup. A design that ignores the invalid flag, or acts on an unqualified request, would corrupt a slot that later lookups expose.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // Next allocation slot, wrapping at the slot count.
  function automatic int unsigned vc_next_slot(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Unsigned width needed to index n slots, at least one bit.
  function automatic int unsigned vc_idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] key,
  input  logic [ADDR_W-1:0] tag_q [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] valid_q,
  output logic [N_ENTRIES-1:0] match
);
  // One comparator per slot, all evaluated together.
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == key);
  end
endmodule

// File: rtl/vc_alloc_ptr.sv
module vc_alloc_ptr #(
  parameter int N_ENTRIES = 4,
  localparam int IW = vc_pkg::vc_idx_width(N_ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= IW'(vc_pkg::vc_next_slot(int'(ptr), N_ENTRIES));
  end
endmodule

// File: rtl/vc_entries.sv
module vc_entries #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 12,
  parameter int LINE_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ENTRIES-1:0] wr_en,
  input  logic [N_ENTRIES-1:0] clr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [LINE_W-1:0]    wr_data,
  output logic [ADDR_W-1:0]    tag_q  [N_ENTRIES],
  output logic [LINE_W-1:0]    data_q [N_ENTRIES],
  output logic [N_ENTRIES-1:0] valid_q
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en[g]) begin
        valid_q[g] <= 1'b1;
      end else if (clr_en[g]) begin
        valid_q[g] <= 1'b0;
      end
    end
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        tag_q[g]  <= wr_addr;
        data_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 12,
  parameter int LINE_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_data,
  output logic              lk_fwd,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [LINE_W-1:0] ins_data,
  input  logic              sw_req,
  input  logic              sw_vic_valid,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [LINE_W-1:0] sw_data
);
  localparam int IW = vc_pkg::vc_idx_width(N_ENTRIES);

  logic [ADDR_W-1:0]    tag_q  [N_ENTRIES];
  logic [LINE_W-1:0]    data_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] valid_q;
  logic [N_ENTRIES-1:0] lk_match, ins_match, alloc_sel, wr_en, clr_en;
  logic [IW-1:0]        ptr;
  logic [LINE_W-1:0]    slot_data;
  logic                 ins_resident, lk_bypass, stored_hit, swap_fire, ptr_adv;

  vc_entries #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_entries (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr_en(clr_en),
    .wr_addr(ins_valid ? ins_addr : sw_addr),
    .wr_data(ins_valid ? ins_data : sw_data),
    .tag_q(tag_q), .data_q(data_q), .valid_q(valid_q)
  );

  vc_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
    .key(lk_addr), .tag_q(tag_q), .valid_q(valid_q), .match(lk_match)
  );

  vc_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_ins_match (
    .key(ins_addr), .tag_q(tag_q), .valid_q(valid_q), .match(ins_match)
  );

  vc_alloc_ptr #(.N_ENTRIES(N_ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(ptr_adv), .ptr(ptr)
  );

  // Named events used by the bound checker.
  assign ins_resident = |ins_match;
  assign ptr_adv      = ins_valid && !ins_resident;
  assign stored_hit   = lk_valid && (|lk_match);
  assign lk_bypass    = lk_valid && ins_valid && (ins_addr == lk_addr);
  assign swap_fire    = sw_req && stored_hit && !ins_valid;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ctl
    assign alloc_sel[g] = (ptr == IW'(g));
    assign wr_en[g]  = (ins_valid && (ins_resident ? ins_match[g] : alloc_sel[g]))
                     || (swap_fire && lk_match[g] && sw_vic_valid);
    assign clr_en[g] = swap_fire && lk_match[g] && !sw_vic_valid;
  end

  always_comb begin
    slot_data = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (lk_match[i]) slot_data = slot_data | data_q[i];
    end
  end

  assign lk_hit  = lk_bypass || stored_hit;
  assign lk_data = lk_bypass ? ins_data : (stored_hit ? slot_data : '0);
  assign lk_fwd  = lk_valid && !lk_hit;
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int N_ENTRIES = 4,
  localparam int IW = vc_pkg::vc_idx_width(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_valid,
  input logic                 lk_hit,
  input logic                 lk_fwd,
  input logic                 ins_valid,
  input logic                 sw_req,
  input logic                 sw_vic_valid,
  input logic [N_ENTRIES-1:0] valid_q,
  input logic [N_ENTRIES-1:0] lk_match,
  input logic [IW-1:0]        ptr,
  input logic                 ptr_adv,
  input logic                 swap_fire
);
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (valid_q == '0));

  p_unique_tags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  p_fwd_is_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fwd |-> (lk_valid && !lk_hit));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_fwd));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv |=> (ptr == IW'(vc_pkg::vc_next_slot(int'($past(ptr)), N_ENTRIES))));

  p_resident_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ptr_adv) |=> ($stable(ptr) && $stable(valid_q)));

  p_swap_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_fire && sw_vic_valid) |=> ($countones(valid_q) == $countones($past(valid_q))));

  p_swap_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_fire && !sw_vic_valid) |=> ($countones(valid_q) + 1 == $countones($past(valid_q))));

  p_swap_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !ins_valid && !lk_hit) |=> ($stable(valid_q) && $stable(ptr)));
endmodule

bind victim_buffer vc_checker #(.N_ENTRIES(N_ENTRIES)) u_vc_checker (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_fwd(lk_fwd),
  .ins_valid(ins_valid), .sw_req(sw_req), .sw_vic_valid(sw_vic_valid),
  .valid_q(valid_q), .lk_match(lk_match), .ptr(ptr), .ptr_adv(ptr_adv),
  .swap_fire(swap_fire)
);

// File: tb/tb_victim_buffer.sv
module tb_victim_buffer;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int LW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, ins_valid = 0, sw_req = 0, sw_vic_valid = 0;
  logic [AW-1:0] lk_addr = '0, ins_addr = '0, sw_addr = '0;
  logic [LW-1:0] ins_data = '0, sw_data = '0;
  logic lk_hit, lk_fwd;
  logic [LW-1:0] lk_data;

  int checks = 0, errors = 0;
  logic [AW-1:0] m_tag [N];
  logic [LW-1:0] m_dat [N];
  logic          m_val [N];
  int            m_ptr;
  int unsigned   fresh = 100;

  always #5ns clk = ~clk;

  victim_buffer #(.N_ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_data(lk_data), .lk_fwd(lk_fwd),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
    .sw_req(sw_req), .sw_vic_valid(sw_vic_valid), .sw_addr(sw_addr), .sw_data(sw_data)
  );

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive, check combinational answer, then update the model at the edge.
  task automatic step(input logic lv, input logic [AW-1:0] la, input logic iv,
                      input logic [AW-1:0] ia, input logic [LW-1:0] id, input logic sr,
                      input logic svv, input logic [AW-1:0] sa, input logic [LW-1:0] sd,
                      input string tag);
    int k, j;
    logic eh;
    logic [LW-1:0] ed;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; ins_valid = iv; ins_addr = ia; ins_data = id;
    sw_req = sr; sw_vic_valid = svv; sw_addr = sa; sw_data = sd;
    #1ns;
    k = find(la);
    if (lv && iv && ia == la) begin eh = 1; ed = id; end
    else if (lv && k >= 0)    begin eh = 1; ed = m_dat[k]; end
    else                      begin eh = 0; ed = '0; end
    check({tag, " hit"}, LW'(lk_hit), LW'(eh));
    check({tag, " data"}, lk_data, ed);
    check({"R3 fwd"}, LW'(lk_fwd), LW'(lv && !eh));
    @(posedge clk);
    if (iv) begin
      j = find(ia);
      if (j >= 0) m_dat[j] = id;
      else begin
        m_tag[m_ptr] = ia; m_dat[m_ptr] = id; m_val[m_ptr] = 1'b1;
        m_ptr = (m_ptr + 1) % N;
      end
    end else if (sr && lv && k >= 0) begin
      if (svv) begin m_tag[k] = sa; m_dat[k] = sd; end
      else m_val[k] = 1'b0;
    end
  endtask

  task automatic look(input logic [AW-1:0] a, input string tag);
    step(1, a, 0, '0, '0, 0, 0, '0, '0, tag);
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [LW-1:0] d);
    step(0, '0, 1, a, d, 0, 0, '0, '0, "R4");
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(12'd1, "R1");
    look(12'd0, "R1");
    // R4: fill past capacity, earliest line lost
    for (int i = 1; i <= 5; i++) put(AW'(i), LW'(64'hA000 + i));
    look(12'd1, "R4 evicted oldest");
    look(12'd5, "R4 newest");
    look(12'd2, "R2 resident");
    // R5: re-insert resident address, pointer unchanged
    put(12'd3, 64'hBEEF);
    look(12'd3, "R5 overwrite");
    put(12'd6, 64'hC006);
    look(12'd2, "R5 pointer held");
    look(12'd4, "R5 neighbour kept");
    // R6: same-cycle insert and lookup
    step(1, 12'd7, 1, 12'd7, 64'hD007, 0, 0, '0, '0, "R6 bypass");
    look(12'd7, "R6 stored");
    // R7: swap with valid then invalid displaced line
    step(1, 12'd7, 0, '0, '0, 1, 1, 12'd50, 64'hE050, "R7 swap");
    look(12'd50, "R7 swapped in");
    look(12'd7, "R7 swapped out");
    step(1, 12'd50, 0, '0, '0, 1, 0, 12'd51, 64'h0, "R7 drop");
    look(12'd50, "R7 invalidated");
    // R8: swap ignored on miss and alongside insert
    step(1, 12'd99, 0, '0, '0, 1, 1, 12'd60, 64'hF060, "R8 miss");
    look(12'd60, "R8 no swap on miss");
    step(1, 12'd6, 1, 12'd8, 64'h8008, 1, 1, 12'd61, 64'hF061, "R8 insert");
    look(12'd61, "R8 no swap with insert");
    look(12'd6, "R8 slot kept");

    // Constrained random traffic
    for (int c = 0; c < 3000; c++) begin
      logic lv, iv, sr, svv;
      logic [AW-1:0] la, ia, sa;
      int r;
      lv = ($urandom % 10) < 7;
      iv = ($urandom % 10) < 3;
      sr = ($urandom % 2) == 1;
      svv = ($urandom % 4) != 0;
      r = int'($urandom % N);
      la = (($urandom % 2) == 1 && m_val[r]) ? m_tag[r] : AW'($urandom % 10);
      ia = AW'($urandom % 10);
      fresh++;
      sa = AW'(fresh);
      step(lv, la, iv, ia, {$urandom, $urandom}, sr, svv, sa, {$urandom, $urandom}, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule